// File: doc/BRIEF.md
# Eight-Channel DMA Interrupt Status and Routing Controller

This block keeps the interrupt state of an eight-channel Ethernet DMA engine. Each channel's transmit and receive DMA paths send single-cycle event pulses. The block latches each pulse into that channel's status register, where it stays until software clears it.

From the latched events and a per-channel enable register, the block builds four summary flags for each channel:

- transmit normal
- receive normal
- transmit abnormal
- receive abnormal

These flags drive one interrupt line for each channel and direction. The lines are laid out on a message-vector bus in reversed channel order. Vector 0 carries a common line that is set whenever any per-channel line is set.

Software reaches the registers through a simple single-cycle register bus. Each channel has three words: a free-format bus-mode word, the status word and the enable word. Address bit `ADDR_W-1` selects a global space. In that space, address 0 holds an identification word whose low byte marks the multi-channel variant.

Top module: `dmairq_top`

## Requirements
- R1: An event pulse on input bit b of a channel (b one of 0,1,3,4,5,6,7,8,9,10,12,13,14) sets status bit b of that channel at the next clock edge. With no further event and no clearing write, the bit then holds its value.
- R2: Writing the status word clears each latched event bit written as 1 and leaves each bit written as 0 unchanged.
- R3: An event pulse in the same cycle as a clearing write to the same status bit wins: the bit stays set.
- R4: Status bit 18 (transmit normal) reads 1 when event bit 0 (transmit done) is latched and enable bit 0 is set. Status bit 17 (receive normal) reads 1 when event bit 6 (receive done) or event bit 14 (early receive) is latched with its own enable bit set.
- R5: Status bit 16 (transmit abnormal) reads 1 when any of event bits 1, 3, 5, 10 or 13 is latched with its own enable bit set. These are stopped, jabber, underflow, early transmit and transmit bus error. Status bit 15 (receive abnormal) does the same for event bits 4, 7, 8, 9 and 12. These are overflow, no buffer, stopped, watchdog and receive bus error.
- R6: Summary bits 15 to 18 are computed, not stored: writing them has no effect. Event input bits 2 and 11 are ignored. Status and enable bits 2, 11 and 31:19 read 0, and enable bits 15 to 18 are writable.
- R7: A channel's transmit line is (bit 18 and enable 18) or (bit 16 and enable 16). Its receive line is (bit 17 and enable 17) or (bit 15 and enable 15). Both are visible in the same cycle the status changes.
- R8: The receive line of channel 7-i drives vector 1+2i and the transmit line of channel 7-i drives vector 2+2i. The vector bus is 32 wide, which is twice the channel count plus one, rounded up to a power of two. Unused vectors read 0.
- R9: Vector 0 is the OR of all per-channel lines.
- R10: The identification word (global address 0) reads 0x00000010.
- R11: Each channel's bus-mode word stores any 32-bit value written to it, independently of other channels.
- R12: Synchronous reset clears all status, enable and mode words and all vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (6) | Word address: bits [1:0] select the field (0 mode, 1 status, 2 enable), the next bits select the channel, and the top bit selects the global space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_i | input | CH*15 (120) | Event pulses, channel c at bits [15c+14:15c] |
| irq_vec_o | output | NVEC (32) | Interrupt vector lines |

## Verification
A wrongly latched or wrongly cleared event bit shows up on the read bus and, when enabled, on the interrupt vector in the same cycle as the edge that stored it. A later, unrelated access cannot hide it. A fault in the summary logic or the enable gating shows as a wrong bit in status positions 15 to 18, or as a vector line that fails to rise or to fall. A routing fault lights a vector that belongs to another channel. Every table entry therefore checks the full status word, the full vector bus, and the return to zero after the clear.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int REG_W = 32;
    localparam int EV_W  = 15;

    // status bit positions used by summary decode
    localparam int B_TX_DONE  = 0;
    localparam int B_TX_STOP  = 1;
    localparam int B_TX_JAB   = 3;
    localparam int B_RX_OVF   = 4;
    localparam int B_TX_UNF   = 5;
    localparam int B_RX_DONE  = 6;
    localparam int B_RX_NOBUF = 7;
    localparam int B_RX_STOP  = 8;
    localparam int B_RX_WDOG  = 9;
    localparam int B_TX_EARLY = 10;
    localparam int B_RX_BUS   = 12;
    localparam int B_TX_BUS   = 13;
    localparam int B_RX_EARLY = 14;
    localparam int B_AIS_RX   = 15;
    localparam int B_AIS_TX   = 16;
    localparam int B_NIS_RX   = 17;
    localparam int B_NIS_TX   = 18;

    localparam logic [REG_W-1:0] TX_NRM_SRC = REG_W'(1) << B_TX_DONE;
    localparam logic [REG_W-1:0] RX_NRM_SRC = (REG_W'(1) << B_RX_DONE)
                                            | (REG_W'(1) << B_RX_EARLY);
    localparam logic [REG_W-1:0] TX_ABN_SRC = (REG_W'(1) << B_TX_STOP)
                                            | (REG_W'(1) << B_TX_JAB)
                                            | (REG_W'(1) << B_TX_UNF)
                                            | (REG_W'(1) << B_TX_EARLY)
                                            | (REG_W'(1) << B_TX_BUS);
    localparam logic [REG_W-1:0] RX_ABN_SRC = (REG_W'(1) << B_RX_OVF)
                                            | (REG_W'(1) << B_RX_NOBUF)
                                            | (REG_W'(1) << B_RX_STOP)
                                            | (REG_W'(1) << B_RX_WDOG)
                                            | (REG_W'(1) << B_RX_BUS);
    localparam logic [REG_W-1:0] EV_MASK  = TX_NRM_SRC | RX_NRM_SRC
                                          | TX_ABN_SRC | RX_ABN_SRC;
    localparam logic [REG_W-1:0] SUM_MASK = (REG_W'(1) << B_AIS_RX)
                                          | (REG_W'(1) << B_AIS_TX)
                                          | (REG_W'(1) << B_NIS_RX)
                                          | (REG_W'(1) << B_NIS_TX);
    localparam logic [REG_W-1:0] EN_MASK  = EV_MASK | SUM_MASK;

    typedef enum logic [1:0] {
        FLD_MODE = 2'd0,
        FLD_STS  = 2'd1,
        FLD_EN   = 2'd2,
        FLD_RSV  = 2'd3
    } field_e;

    typedef struct packed {
        logic nis_tx;
        logic nis_rx;
        logic ais_tx;
        logic ais_rx;
    } sum_t;

    function automatic int vec_count(input int ch);
        int n;
        n = 1;
        while (n < 2 * ch + 1) n = n * 2;
        return n;
    endfunction

    function automatic sum_t make_sum(input logic [REG_W-1:0] lat,
                                      input logic [REG_W-1:0] en);
        logic [REG_W-1:0] act;
        sum_t s;
        act      = lat & en;
        s.nis_tx = |(act & TX_NRM_SRC);
        s.nis_rx = |(act & RX_NRM_SRC);
        s.ais_tx = |(act & TX_ABN_SRC);
        s.ais_rx = |(act & RX_ABN_SRC);
        return s;
    endfunction

endpackage

// File: rtl/dmairq_chan.sv
module dmairq_chan
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EV_W-1:0]  ev_i,
    input  logic             wr_mode,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mode_o,
    output logic [REG_W-1:0] sts_o,
    output logic [REG_W-1:0] en_o,
    output logic             irq_tx_o,
    output logic             irq_rx_o
);

    logic [REG_W-1:0] lat_q, lat_d, en_q, mode_q, ev_m, clr_m;
    sum_t             sum;

    always_comb begin
        ev_m  = REG_W'(ev_i) & EV_MASK;
        clr_m = wr_sts ? wdata : '0;
        // a new event takes priority over a same-cycle clear
        lat_d = (lat_q & ~clr_m) | ev_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            en_q   <= '0;
            mode_q <= '0;
        end else begin
            lat_q <= lat_d;
            if (wr_en)   en_q   <= wdata & EN_MASK;
            if (wr_mode) mode_q <= wdata;
        end
    end

    always_comb begin
        sum             = make_sum(lat_q, en_q);
        sts_o           = lat_q;
        sts_o[B_NIS_TX] = sum.nis_tx;
        sts_o[B_NIS_RX] = sum.nis_rx;
        sts_o[B_AIS_TX] = sum.ais_tx;
        sts_o[B_AIS_RX] = sum.ais_rx;
        irq_tx_o = (sum.nis_tx & en_q[B_NIS_TX]) | (sum.ais_tx & en_q[B_AIS_TX]);
        irq_rx_o = (sum.nis_rx & en_q[B_NIS_RX]) | (sum.ais_rx & en_q[B_AIS_RX]);
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;

    // R1: latched events hold without events or writes
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!wr_sts && ev_m == '0) |=> $stable(lat_q));

    // R2: written ones with no colliding event clear
    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && ((wdata & ~ev_m & EV_MASK) != '0))
        |=> ((lat_q & $past(wdata & ~ev_m & EV_MASK)) == '0));

    // R3: an arriving event is always latched, clear or not
    assert_ev_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_m != '0) |=> ((lat_q & $past(ev_m)) == $past(ev_m)));

    // R7: a line can only be up with a summary enable set
    assert_tx_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq_tx_o |-> (en_q[B_NIS_TX] || en_q[B_AIS_TX]));
    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq_rx_o |-> (en_q[B_NIS_RX] || en_q[B_AIS_RX]));

    // R12: reset leaves the channel empty
    assert_rst_clear_R12: assert property (@(posedge clk)
        $past(rst) |-> (lat_q == '0 && en_q == '0 && mode_q == '0));

endmodule

// File: rtl/dmairq_vecmap.sv
module dmairq_vecmap
    import dmairq_pkg::*;
#(
    parameter  int CH   = 8,
    localparam int NVEC = vec_count(CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH-1:0]   irq_tx_i,
    input  logic [CH-1:0]   irq_rx_i,
    output logic [NVEC-1:0] vec_o
);

    always_comb begin
        vec_o    = '0;
        vec_o[0] = (|irq_tx_i) | (|irq_rx_i);
        for (int i = 0; i < CH; i++) begin
            vec_o[1 + 2 * i] = irq_rx_i[CH - 1 - i];
            vec_o[2 + 2 * i] = irq_tx_i[CH - 1 - i];
        end
    end

    // R9: common line tracks the routed per-channel lines
    assert_common_R9: assert property (@(posedge clk) disable iff (rst)
        vec_o[0] == (vec_o[NVEC-1:1] != '0));

    // R8: a routed line count never exceeds the channel lines
    assert_route_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(vec_o[NVEC-1:1]) == ($countones(irq_tx_i) + $countones(irq_rx_i)));

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter  int         CH         = 8,
    parameter  logic [7:0] VERSION_ID = 8'h10,
    localparam int         CH_W       = (CH > 1) ? $clog2(CH) : 1,
    localparam int         ADDR_W     = CH_W + 3,
    localparam int         NVEC       = vec_count(CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [CH*EV_W-1:0] evt_i,
    output logic [NVEC-1:0]   irq_vec_o
);

    logic              glob_sel;
    logic [CH_W-1:0]   ch_sel;
    field_e            fld;
    logic [REG_W-1:0]  mode_w [CH];
    logic [REG_W-1:0]  sts_w  [CH];
    logic [REG_W-1:0]  en_w   [CH];
    logic [CH-1:0]     irq_tx, irq_rx;

    assign glob_sel = bus_addr[ADDR_W-1];
    assign ch_sel   = bus_addr[CH_W+1:2];
    assign fld      = field_e'(bus_addr[1:0]);

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_wr && !glob_sel && (32'(ch_sel) == c);

        dmairq_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .ev_i     (evt_i[c*EV_W +: EV_W]),
            .wr_mode  (hit && fld == FLD_MODE),
            .wr_sts   (hit && fld == FLD_STS),
            .wr_en    (hit && fld == FLD_EN),
            .wdata    (bus_wdata),
            .mode_o   (mode_w[c]),
            .sts_o    (sts_w[c]),
            .en_o     (en_w[c]),
            .irq_tx_o (irq_tx[c]),
            .irq_rx_o (irq_rx[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (glob_sel) begin
            if (bus_addr[ADDR_W-2:0] == '0) bus_rdata = REG_W'(VERSION_ID);
        end else if (32'(ch_sel) < CH) begin
            unique case (fld)
                FLD_MODE: bus_rdata = mode_w[ch_sel];
                FLD_STS:  bus_rdata = sts_w[ch_sel];
                FLD_EN:   bus_rdata = en_w[ch_sel];
                default:  bus_rdata = '0;
            endcase
        end
    end

    dmairq_vecmap #(.CH(CH)) u_vecmap (
        .clk      (clk),
        .rst      (rst),
        .irq_tx_i (irq_tx),
        .irq_rx_i (irq_rx),
        .vec_o    (irq_vec_o)
    );

    // R10: identification word is constant outside reset
    assert_ident_R10: assert property (@(posedge clk) disable iff (rst)
        (glob_sel && bus_addr[ADDR_W-2:0] == '0) |-> (bus_rdata[7:0] == VERSION_ID));

endmodule

// File: tb/sim_dmairq_top.sv
module sim_dmairq_top;

    localparam int CH = 8;
    localparam int EW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [CH*EW-1:0] evt = '0;
    logic [31:0]   irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dmairq_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt), .irq_vec_o(irq_vec)
    );

    typedef struct packed {
        logic [31:0] ch;
        logic [31:0] ev;
        logic [31:0] en;
        logic [31:0] sts;
        logic        tx;
        logic        rx;
    } row_t;

    // channel, event pulse, enable, expected status, expected tx, rx line
    localparam row_t TBL [8] = '{
        '{32'd0, 32'h00001, 32'h40001, 32'h40001, 1'b1, 1'b0},
        '{32'd3, 32'h00040, 32'h20040, 32'h20040, 1'b0, 1'b1},
        '{32'd5, 32'h02000, 32'h12000, 32'h12000, 1'b1, 1'b0},
        '{32'd7, 32'h00010, 32'h00010, 32'h08010, 1'b0, 1'b0},
        '{32'd2, 32'h04000, 32'h00000, 32'h04000, 1'b0, 1'b0},
        '{32'd6, 32'h00220, 32'h18220, 32'h18220, 1'b1, 1'b1},
        '{32'd1, 32'h00080, 32'h20080, 32'h08080, 1'b0, 1'b0},
        '{32'd4, 32'h00008, 32'h7F7FB, 32'h10008, 1'b1, 1'b0}
    };

    function automatic logic [31:0] exp_vec(int ch, logic tx, logic rx);
        logic [31:0] v;
        v = '0;
        v[1 + 2 * (CH - 1 - ch)] = rx;
        v[2 + 2 * (CH - 1 - ch)] = tx;
        v[0] = tx | rx;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(int ch, logic [14:0] ev);
        @(negedge clk);
        evt[ch*EW +: EW] = ev;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic logic [5:0] ad(int ch, int f);
        return 6'(ch * 4 + f);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        for (int c = 0; c < CH; c++) begin
            rd(ad(c, 0), d); check("R12 mode reset", d, 32'h0);
            rd(ad(c, 1), d); check("R12 status reset", d, 32'h0);
            rd(ad(c, 2), d); check("R12 enable reset", d, 32'h0);
        end
        check("R12 vectors reset", irq_vec, 32'h0);

        // R10 identification
        rd(6'h20, d); check("R10 ident", d, 32'h10);

        // table: R1 R4 R5 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            int c;
            c = int'(TBL[i].ch);
            wr(ad(c, 2), TBL[i].en);
            pulse(c, TBL[i].ev[14:0]);
            rd(ad(c, 1), d); check("R1/R4/R5 status", d, TBL[i].sts);
            check("R7/R8/R9 vectors", irq_vec, exp_vec(c, TBL[i].tx, TBL[i].rx));
            repeat (2) @(negedge clk);
            rd(ad(c, 1), d); check("R1 status holds", d, TBL[i].sts);
            wr(ad(c, 1), 32'hFFFF_FFFF);
            wr(ad(c, 2), 32'h0);
            rd(ad(c, 1), d); check("R2 full clear", d, 32'h0);
            check("R7 lines drop", irq_vec, 32'h0);
        end

        // R2 partial clear and zero write
        pulse(0, 15'h0041);
        wr(ad(0, 1), 32'h0);
        rd(ad(0, 1), d); check("R2 zero write keeps", d, 32'h41);
        wr(ad(0, 1), 32'h1);
        rd(ad(0, 1), d); check("R2 partial clear", d, 32'h40);
        wr(ad(0, 1), 32'h40);

        // R3 event beats same-cycle clear
        pulse(1, 15'h0001);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ad(1, 1); bus_wdata = 32'h1;
        evt[1*EW +: EW] = 15'h0001;
        @(negedge clk);
        bus_wr = 1'b0; evt = '0;
        rd(ad(1, 1), d); check("R3 event wins", d, 32'h1);
        wr(ad(1, 1), 32'h1);
        rd(ad(1, 1), d); check("R3 later clear", d, 32'h0);

        // R6 ignored inputs, reserved bits, summary writes
        pulse(2, 15'h0804);
        rd(ad(2, 1), d); check("R6 ignored event bits", d, 32'h0);
        wr(ad(2, 2), 32'hFFFF_FFFF);
        rd(ad(2, 2), d); check("R6 enable mask", d, 32'h0007_F7FB);
        pulse(2, 15'h0010);
        wr(ad(2, 1), 32'h0007_8000);
        rd(ad(2, 1), d); check("R6 summary write no effect", d, 32'h0000_8010);
        check("R6 rx line after summary write", irq_vec, exp_vec(2, 1'b0, 1'b1));
        wr(ad(2, 1), 32'hFFFF_FFFF);
        wr(ad(2, 2), 32'h0);

        // R11 mode words independent
        wr(ad(2, 0), 32'h1234_5678);
        rd(ad(2, 0), d); check("R11 mode stored", d, 32'h1234_5678);
        rd(ad(3, 0), d); check("R11 neighbour untouched", d, 32'h0);

        // R8/R9 two channels at once
        wr(ad(0, 2), 32'h0004_0001);
        wr(ad(7, 2), 32'h0002_0040);
        pulse(0, 15'h0001);
        pulse(7, 15'h0040);
        check("R8 two channels", irq_vec, exp_vec(0, 1'b1, 1'b0) | exp_vec(7, 1'b0, 1'b1));

        // R12 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12 vectors after reset", irq_vec, 32'h0);
        rd(ad(0, 1), d); check("R12 status after reset", d, 32'h0);
        rd(ad(2, 0), d); check("R12 mode after reset", d, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule